// File: doc/BRIEF.md
# Protection Fault Monitor with First-Trip Timestamp

This block sits in a machine-protection chain. It watches a group of hardware fault lines, a heartbeat pulse taken from the timing link, and timestamps carried on the link's data channel. From these it drives two beam-permit outputs. A free-running tick counter advances on every link-clock edge. It supplies the time base, so every trip is stamped to one link-clock period. For each source the block keeps a sticky latch. It also records which source tripped first and when, so that faults can be correlated afterwards.

The active beam mode selects which fault lines count. Two extra sources are always enabled. The first is a heartbeat watchdog, which fires when the cycle-start pulse stops arriving. The second is a timestamp sanity check, which fires when the link time stalls or jumps. The auto-reset permit comes back by itself on a cycle start. The latched permit needs an explicit clear.

Top module: `prot_fault_monitor`

## Requirements
- R1: `tick_o` is 0 while reset is held. After reset it rises by exactly one on every clock edge and wraps at its width.
- R2: The set of enabled fault lines comes from a per-mode table. By default, mode 0 enables all eight lines, mode 1 enables lines 0 to 3, mode 2 enables lines 4 to 7, and mode 3 enables lines 0 and 7 only. A masked line has no effect on the permits, the trip latches or the first-trip record.
- R3: `trip_vec_o` holds one sticky bit per source. Bits 0 to N_IN-1 are the fault lines, bit N_IN is the heartbeat watchdog and bit N_IN+1 is the timestamp check. A bit is set on the edge after its source goes active. It is cleared only by `clear_i`, and a change of mode does not clear it.
- R4: The first source to become active after reset or after a clear is stored in `first_src_o`, with `first_valid_o` high. The tick value in the cycle the source was seen is stored in `first_time_o`. If several sources appear in the same cycle, the lowest index wins. The record is held until `clear_i`.
- R5: The heartbeat source goes active once HB_LIMIT clock edges have passed with no `cycle_start_i`. A cycle start re-arms the watchdog.
- R6: Each `link_ts_valid_i` sample after the first is compared with the previous sample. A difference below TS_DMIN or above TS_DMAX makes the timestamp source active until the next sample that falls within range.
- R7: Both permits go low on the edge after any enabled source is active.
- R8: `permit_auto_o` goes high only on an edge with `cycle_start_i` high and no active source.
- R9: `permit_latch_o` goes high only on an edge with `clear_i` high and no active source.
- R10: After reset, both permits are low, `trip_vec_o` is 0 and `first_valid_o` is low.
- R11: `last_time_o` holds the tick value of the most recent cycle in which any source newly latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_i | input | N_IN | Fault lines, active high |
| mode_i | input | MODE_W | Beam mode selecting the enable mask |
| cycle_start_i | input | 1 | Cycle-start heartbeat pulse |
| link_ts_valid_i | input | 1 | Link timestamp sample strobe |
| link_ts_i | input | TS_W | Link timestamp value |
| clear_i | input | 1 | Clears latches and rearms latched permit |
| tick_o | output | TICK_W | Fine time counter |
| permit_auto_o | output | 1 | Auto-reset beam permit |
| permit_latch_o | output | 1 | Latched beam permit |
| trip_vec_o | output | N_IN+2 | Sticky per-source trip bits |
| first_valid_o | output | 1 | First-trip record valid |
| first_src_o | output | $clog2(N_IN+2) | Index of first tripped source |
| first_time_o | output | TICK_W | Tick of first trip |
| last_time_o | output | TICK_W | Tick of most recent new trip |

## Verification
Every fault line is tripped alone in every mode, and the results are compared with the mode table. This separates enabled lines from masked ones, and it checks the recorded index and tick for each line. Every pair of lines is tripped in the same cycle to check that the lowest index wins. A staggered pair separates the first-trip time from the last-trip time. The heartbeat is withheld until exactly the limit to probe the cycle on which it fires. The timestamp check receives steps at the minimum, at the maximum, a stall, and one step past the maximum. A mode change after a trip shows that latched bits survive it.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  // lowest set bit of a vector of up to 32 sources
  function automatic logic [4:0] lowest_idx(input logic [31:0] v);
    lowest_idx = '0;
    for (int k = 31; k >= 0; k--) begin
      if (v[k]) lowest_idx = 5'(k);
    end
  endfunction
endpackage

// File: rtl/pfm_heartbeat.sv
module pfm_heartbeat #(
  parameter int unsigned LIMIT = 400000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cycle_start_i,
  output logic fault_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (cycle_start_i)       cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign fault_o = (cnt_q == CW'(LIMIT));

  AST_HB_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_start_i |=> !fault_o); // R5
  AST_HB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && !cycle_start_i |=> fault_o); // R5
endmodule

// File: rtl/pfm_ts_check.sv
module pfm_ts_check #(
  parameter int unsigned TS_W  = 32,
  parameter int unsigned DMIN  = 1,
  parameter int unsigned DMAX  = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [TS_W-1:0] ts_i,
  output logic            fault_o
);
  logic [TS_W-1:0] prev_q;
  logic            have_q;
  logic [TS_W-1:0] delta;
  logic            bad;

  assign delta = ts_i - prev_q;
  assign bad   = (delta < TS_W'(DMIN)) || (delta > TS_W'(DMAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      have_q  <= 1'b0;
      fault_o <= 1'b0;
    end else if (valid_i) begin
      prev_q  <= ts_i;
      have_q  <= 1'b1;
      fault_o <= have_q && bad;
    end
  end

  AST_TS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(fault_o)); // R6
  AST_TS_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !have_q |=> !fault_o); // R6
endmodule

// File: rtl/pfm_trip_latch.sv
module pfm_trip_latch #(
  parameter int unsigned NSRC   = 10,
  parameter int unsigned SRC_W  = 4,
  parameter int unsigned TICK_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   active_i,
  input  logic              clear_i,
  input  logic [TICK_W-1:0] tick_i,
  output logic [NSRC-1:0]   trip_o,
  output logic              first_valid_o,
  output logic [SRC_W-1:0]  first_src_o,
  output logic [TICK_W-1:0] first_time_o,
  output logic [TICK_W-1:0] last_time_o
);
  import pfm_pkg::*;

  logic [NSRC-1:0] base, new_v;
  logic            fv_base;

  // clear acts as if nothing was latched before this edge
  assign base    = clear_i ? '0 : trip_o;
  assign fv_base = clear_i ? 1'b0 : first_valid_o;
  assign new_v   = active_i & ~base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_o        <= '0;
      first_valid_o <= 1'b0;
      first_src_o   <= '0;
      first_time_o  <= '0;
      last_time_o   <= '0;
    end else begin
      trip_o <= base | active_i;
      if (|new_v) last_time_o <= tick_i;
      if (!fv_base && |new_v) begin
        first_valid_o <= 1'b1;
        first_src_o   <= SRC_W'(lowest_idx(32'(new_v)));
        first_time_o  <= tick_i;
      end else if (clear_i) begin
        first_valid_o <= 1'b0;
      end
    end
  end

  AST_TRIP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (trip_o & $past(trip_o)) == $past(trip_o)); // R3
  AST_FIRST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_valid_o && !clear_i |=> $stable(first_src_o) && $stable(first_time_o)); // R4
  AST_FIRST_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_valid_o |-> trip_o[first_src_o]); // R4
endmodule

// File: rtl/pfm_permit.sv
module pfm_permit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_i,
  input  logic cycle_start_i,
  input  logic clear_i,
  output logic auto_o,
  output logic latch_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_o  <= 1'b0;
      latch_o <= 1'b0;
    end else begin
      if (any_i)              auto_o <= 1'b0;
      else if (cycle_start_i) auto_o <= 1'b1;
      if (any_i)              latch_o <= 1'b0;
      else if (clear_i)       latch_o <= 1'b1;
    end
  end

  AST_AUTO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_i |=> !auto_o); // R7
  AST_LATCH_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_i |=> !latch_o); // R7
  AST_AUTO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_o ##1 auto_o |-> $past(cycle_start_i)); // R8
  AST_LATCH_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_o ##1 latch_o |-> $past(clear_i)); // R9
endmodule

// File: rtl/prot_fault_monitor.sv
module prot_fault_monitor #(
  parameter int unsigned N_IN     = 8,
  parameter int unsigned MODE_W   = 2,
  parameter logic [(N_IN<<MODE_W)-1:0] MODE_EN = 'h81F00FFF,
  parameter int unsigned TICK_W   = 32,
  parameter int unsigned TS_W     = 32,
  parameter int unsigned HB_LIMIT = 400000,
  parameter int unsigned TS_DMIN  = 1,
  parameter int unsigned TS_DMAX  = 1,
  localparam int unsigned NSRC    = N_IN + 2,
  localparam int unsigned SRC_W   = $clog2(NSRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IN-1:0]   fault_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              cycle_start_i,
  input  logic              link_ts_valid_i,
  input  logic [TS_W-1:0]   link_ts_i,
  input  logic              clear_i,
  output logic [TICK_W-1:0] tick_o,
  output logic              permit_auto_o,
  output logic              permit_latch_o,
  output logic [NSRC-1:0]   trip_vec_o,
  output logic              first_valid_o,
  output logic [SRC_W-1:0]  first_src_o,
  output logic [TICK_W-1:0] first_time_o,
  output logic [TICK_W-1:0] last_time_o
);
  localparam int unsigned N_MODE = 1 << MODE_W;

  logic [N_IN-1:0] en;
  logic [NSRC-1:0] active;
  logic            hb_fault, ts_fault;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_o <= '0;
    else         tick_o <= tick_o + 1'b1;
  end

  always_comb begin
    en = '0;
    for (int m = 0; m < N_MODE; m++) begin
      if (mode_i == MODE_W'(m)) en = MODE_EN[m*N_IN +: N_IN];
    end
  end

  assign active = {ts_fault, hb_fault, fault_i & en};

  pfm_heartbeat #(.LIMIT(HB_LIMIT)) u_hb (
    .clk_i, .rst_ni, .cycle_start_i, .fault_o(hb_fault)
  );

  pfm_ts_check #(.TS_W(TS_W), .DMIN(TS_DMIN), .DMAX(TS_DMAX)) u_ts (
    .clk_i, .rst_ni, .valid_i(link_ts_valid_i), .ts_i(link_ts_i), .fault_o(ts_fault)
  );

  pfm_trip_latch #(.NSRC(NSRC), .SRC_W(SRC_W), .TICK_W(TICK_W)) u_trip (
    .clk_i, .rst_ni, .active_i(active), .clear_i, .tick_i(tick_o),
    .trip_o(trip_vec_o), .first_valid_o, .first_src_o, .first_time_o, .last_time_o
  );

  pfm_permit u_permit (
    .clk_i, .rst_ni, .any_i(|active), .cycle_start_i, .clear_i,
    .auto_o(permit_auto_o), .latch_o(permit_latch_o)
  );

  AST_TICK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> tick_o == $past(tick_o) + 1'b1); // R1
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i & ~en) != '0 && (fault_i & en) == '0 && !hb_fault && !ts_fault && !clear_i
    |=> $stable(trip_vec_o)); // R2
endmodule

// File: tb/prot_fault_monitor_test.sv
module prot_fault_monitor_test;
  localparam int N_IN = 8;
  localparam int HB   = 64;

  logic        clk = 0, rst_ni = 0;
  logic [7:0]  fault_i = '0;
  logic [1:0]  mode_i = '0;
  logic        cs_i = 0, tsv_i = 0, clr_i = 0;
  logic [15:0] ts_i = '0;
  logic [15:0] tick_o, first_time_o, last_time_o;
  logic        pa_o, pl_o, fv_o;
  logic [9:0]  trip_o;
  logic [3:0]  fs_o;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  prot_fault_monitor #(.N_IN(8), .MODE_W(2), .TICK_W(16), .TS_W(16),
    .HB_LIMIT(HB), .TS_DMIN(1), .TS_DMAX(2)) uut (
    .clk_i(clk), .rst_ni, .fault_i, .mode_i, .cycle_start_i(cs_i),
    .link_ts_valid_i(tsv_i), .link_ts_i(ts_i), .clear_i(clr_i),
    .tick_o, .permit_auto_o(pa_o), .permit_latch_o(pl_o), .trip_vec_o(trip_o),
    .first_valid_o(fv_o), .first_src_o(fs_o), .first_time_o, .last_time_o);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_en(int m, int i);
    case (m)
      0: return 1'b1;
      1: return i < 4;
      2: return i >= 4;
      default: return i == 0 || i == 7;
    endcase
  endfunction

  task automatic nclk(int n); repeat (n) @(negedge clk); endtask
  task automatic pulse_cs(); cs_i = 1; nclk(1); cs_i = 0; endtask
  task automatic pulse_clr(); clr_i = 1; nclk(1); clr_i = 0; endtask
  task automatic restore(); fault_i = '0; pulse_cs(); pulse_clr(); pulse_cs(); endtask
  task automatic send_ts(logic [15:0] v); tsv_i = 1; ts_i = v; nclk(1); tsv_i = 0; endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] t, t2;
    nclk(3);
    chk("R10 permit_auto", 32'(pa_o), 0);
    chk("R10 permit_latch", 32'(pl_o), 0);
    chk("R10 trips", 32'(trip_o), 0);
    chk("R10 first_valid", 32'(fv_o), 0);
    chk("R1 tick in reset", 32'(tick_o), 0);
    rst_ni = 1;
    nclk(5);
    chk("R1 tick count", 32'(tick_o), 5);

    // every line in every mode
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < N_IN; i++) begin
        bit en;
        en = exp_en(m, i);
        mode_i = 2'(m);
        restore();
        chk("R8 auto up", 32'(pa_o), 1);
        chk("R9 latch up", 32'(pl_o), 1);
        t = tick_o;
        fault_i = 8'(1) << i;
        nclk(1);
        chk("R2/R7 auto", 32'(pa_o), 32'(!en));
        chk("R2/R7 latch", 32'(pl_o), 32'(!en));
        chk("R2/R3 trips", 32'(trip_o), en ? (32'(1) << i) : 0);
        chk("R4 first_valid", 32'(fv_o), 32'(en));
        if (en) begin
          chk("R4 first_src", 32'(fs_o), 32'(i));
          chk("R4 first_time", 32'(first_time_o), 32'(t));
          chk("R11 last_time", 32'(last_time_o), 32'(t));
        end
        fault_i = '0;
        nclk(1);
        chk("R8 auto waits cycle start", 32'(pa_o), 32'(!en));
        pulse_cs();
        chk("R8 auto back", 32'(pa_o), 1);
        chk("R9 latch holds", 32'(pl_o), 32'(!en));
        pulse_clr();
        chk("R9 latch back", 32'(pl_o), 1);
        chk("R3 clear", 32'(trip_o), 0);
      end
    end
    mode_i = 0;

    // simultaneous pairs: lowest index wins
    for (int a = 0; a < N_IN; a++) begin
      for (int b = a + 1; b < N_IN; b++) begin
        restore();
        fault_i = (8'(1) << a) | (8'(1) << b);
        nclk(1);
        chk("R4 lowest wins", 32'(fs_o), 32'(a));
      end
    end

    // staggered trips
    restore();
    t = tick_o; fault_i = 8'h20; nclk(1);
    t2 = tick_o; fault_i = 8'h24; nclk(1);
    chk("R4 first staggered", 32'(fs_o), 5);
    chk("R4 first time staggered", 32'(first_time_o), 32'(t));
    chk("R11 last time staggered", 32'(last_time_o), 32'(t2));
    chk("R3 both latched", 32'(trip_o), 32'h24);

    // mode change keeps latch
    restore();
    fault_i = 8'h80; nclk(1); fault_i = 0;
    mode_i = 1; nclk(2);
    chk("R3 mode change keeps trip", 32'(trip_o), 32'h80);
    chk("R4 mode change keeps first", 32'(fs_o), 7);
    mode_i = 0;

    // heartbeat boundary
    restore();
    nclk(HB - 1);
    chk("R5 before limit", 32'(pa_o), 1);
    nclk(1);
    chk("R5 at limit permit still up", 32'(pa_o), 1);
    t = tick_o;
    nclk(1);
    chk("R5 permit down", 32'(pa_o), 0);
    chk("R5 trip bit", 32'(trip_o), 32'h100);
    chk("R5 first src", 32'(fs_o), 8);
    chk("R5 first time", 32'(first_time_o), 32'(t));
    pulse_cs();
    chk("R8 rearm edge not permitted", 32'(pa_o), 0);
    pulse_cs();
    chk("R8 auto after rearm", 32'(pa_o), 1);

    // timestamp checks
    restore();
    send_ts(16'd100); send_ts(16'd101); send_ts(16'd103);
    nclk(1);
    chk("R6 good steps", 32'(pa_o), 1);
    chk("R6 good steps trips", 32'(trip_o), 0);
    send_ts(16'd103);
    nclk(1);
    chk("R6 stall", 32'(pa_o), 0);
    chk("R6 stall src", 32'(fs_o), 9);
    send_ts(16'd104);
    pulse_cs();
    chk("R6 recovered", 32'(pa_o), 1);
    restore();
    send_ts(16'd107);
    nclk(1);
    chk("R6 jump", 32'(pa_o), 0);
    chk("R6 jump trip", 32'(trip_o), 32'h200);
    send_ts(16'd108);
    restore();
    chk("R6 final clean", 32'(pl_o), 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule